// File: doc/BRIEF.md
# Divide Result Sign Correction and Overflow Flagging

This block is the last step of an integer divide unit. The divider core produces an unsigned quotient magnitude and a flag that says whether the true quotient is negative. This stage applies that sign and decides whether the operation overflowed. It then delivers the final 64-bit result and one overflow flag, one cycle after a valid input.

The overflow rule depends on the operand width and the signedness. In 64-bit mode the magnitude is zero-extended to 65 bits and negated when needed. A disagreement between the two top bits of that value marks a signed overflow, and this is combined with an overflow flag from the core. In 32-bit mode only the lower half of the magnitude takes part. The check then uses bits 32 and 31 of a 33-bit signed value, combined with a 32-bit overflow flag computed upstream. Whenever overflow is flagged, the result is forced to zero. Divide-by-zero always counts as overflow.

Top module: `div_result_fix`

## Requirements
- R1: After reset `out_valid`, `result` and `overflow` are 0. An input accepted with `in_valid`=1 appears on the outputs exactly one clock later with `out_valid`=1. Without `in_valid`, `out_valid` is 0 and `result` and `overflow` hold their last values.
- R2: When `mode_signed`=1 and `negate`=1, the result is the two's complement of the magnitude. When `mode_signed`=0, `negate` has no effect.
- R3: In 64-bit mode (`mode_32`=0), `overflow` = `ovf_core` OR (`mode_signed` AND the signed value lies outside the 64-bit two's-complement range), which is the same as bit 64 differing from bit 63 of the 65-bit signed value.
- R4: In 32-bit signed mode, `overflow` = `ovf32` OR (bit 32 differs from bit 31 of the 33-bit signed value formed from the low 32 magnitude bits).
- R5: In 32-bit unsigned mode, `overflow` equals `ovf32` alone. `ovf_core` and the magnitude do not affect it.
- R6: In 32-bit mode, bits 63..32 of `quo_mag` influence neither `overflow` nor `result`. For example, a signed negate of 0xfc00000000000003 gives 0xfffffffffffffffd with no overflow.
- R7: `div_zero`=1 forces `overflow`=1 in every mode.
- R8: When `overflow` is 1, `result` is 0.
- R9: In 32-bit mode, `result` is the low 32 bits of the signed value. These are sign-extended to 64 bits when signed and zero-extended when unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input fields are valid this cycle |
| quo_mag | input | 64 | Unsigned quotient magnitude from the core |
| negate | input | 1 | Quotient must be negated |
| div_zero | input | 1 | Divisor was zero |
| ovf_core | input | 1 | Core overflow flag used in 64-bit mode |
| ovf32 | input | 1 | Precomputed overflow flag used in 32-bit mode |
| mode_32 | input | 1 | 1 = 32-bit operation, 0 = 64-bit |
| mode_signed | input | 1 | 1 = signed operation |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Final quotient, zero when overflow is set |
| overflow | output | 1 | Overflow or divide-by-zero |

## Verification
The block holds state only in its output register. A fault inside it therefore appears at the ports in the cycle right after the offending input: a wrong overflow bit, a nonzero result under overflow, or a wrong extension of the upper half. The bench aims at the places where such a fault would hide. It drives 32-bit operations whose upper magnitude bits are dirty, magnitudes exactly at the signed limits, and `negate` with unsigned modes. It also checks that the outputs keep their values through idle cycles.

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] quo_mag,
  input  logic         negate,
  input  logic         div_zero,
  input  logic         ovf_core,
  input  logic         ovf32,
  input  logic         mode_32,
  input  logic         mode_signed,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         overflow
);
  localparam int H = W / 2;

  logic         do_neg;
  logic [W:0]   s_full;
  logic [H:0]   s_half;
  logic         ovf_w, ovf_h, ovf_n;
  logic [W-1:0] res_half, res_n;

  assign do_neg   = mode_signed & negate;
  assign s_full   = do_neg ? -{1'b0, quo_mag} : {1'b0, quo_mag};
  assign s_half   = do_neg ? -{1'b0, quo_mag[H-1:0]} : {1'b0, quo_mag[H-1:0]};
  assign ovf_w    = ovf_core | (mode_signed & (s_full[W] ^ s_full[W-1]));
  assign ovf_h    = ovf32 | (mode_signed & (s_half[H] ^ s_half[H-1]));
  assign ovf_n    = div_zero | (mode_32 ? ovf_h : ovf_w);
  assign res_half = mode_signed ? {{H{s_half[H-1]}}, s_half[H-1:0]}
                                : {{H{1'b0}}, s_half[H-1:0]};
  assign res_n    = ovf_n ? '0 : (mode_32 ? res_half : s_full[W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res_n;
        overflow <= ovf_n;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(overflow)));
  assert_zero_on_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (result == '0));
  assert_div_zero_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && div_zero) |=> overflow);
  assert_u32_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_32 && !mode_signed) |=> (overflow == $past(ovf32 | div_zero)));
  assert_s32_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_32 && mode_signed) |=> (result[W-1:H] == {H{result[H-1]}}));
  assert_u32_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_32 && !mode_signed) |=> (result[W-1:H] == '0));
endmodule

// File: tb/tb_div_result_fix.sv
`timescale 1ns/1ps
module tb_div_result_fix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] quo_mag = '0;
  logic        negate = 1'b0, div_zero = 1'b0, ovf_core = 1'b0, ovf32 = 1'b0;
  logic        mode_32 = 1'b0, mode_signed = 1'b0;
  logic        out_valid, overflow;
  logic [63:0] result;

  int tests = 0, fails = 0;
  logic        m_valid = 1'b0, m_ovf = 1'b0;
  logic [63:0] m_res = '0;
  string       m_tag = "R1";
  string       cur_tag = "R1";
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  div_result_fix dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .quo_mag(quo_mag),
    .negate(negate), .div_zero(div_zero), .ovf_core(ovf_core), .ovf32(ovf32),
    .mode_32(mode_32), .mode_signed(mode_signed),
    .out_valid(out_valid), .result(result), .overflow(overflow));

  function automatic void model(input logic [63:0] m, input logic ng, dz, cov, o32, w32, sg,
                                output logic [63:0] r, output logic ov);
    logic signed [66:0] v;
    if (w32) begin
      v = $signed({35'b0, m[31:0]});
      if (sg && ng) v = -v;
      ov = o32 | (sg && (v > 67'sd2147483647 || v < -67'sd2147483648));
      r  = sg ? {{32{v[31]}}, v[31:0]} : {32'b0, v[31:0]};
    end else begin
      v = $signed({3'b0, m});
      if (sg && ng) v = -v;
      ov = cov | (sg && (v > 67'sd9223372036854775807 || v < -67'sd9223372036854775808));
      r  = v[63:0];
    end
    ov = ov | dz;
    if (ov) r = '0;
  endfunction

  always @(posedge clk) begin
    logic [63:0] r; logic ov;
    if (!rst_n) begin
      m_valid <= 1'b0; m_res <= '0; m_ovf <= 1'b0; m_tag <= "R1";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        model(quo_mag, negate, div_zero, ovf_core, ovf32, mode_32, mode_signed, r, ov);
        m_res <= r; m_ovf <= ov; m_tag <= cur_tag;
      end else m_tag <= "R1";
    end
  end

  always @(negedge clk) begin
    if (!done && $time > 20) begin
      tests++;
      if (out_valid !== m_valid || result !== m_res || overflow !== m_ovf) begin
        fails++;
        $display("FAIL %s: got v=%0b res=%h ovf=%0b, expected v=%0b res=%h ovf=%0b",
                 m_tag, out_valid, result, overflow, m_valid, m_res, m_ovf);
      end
    end
  end

  task automatic op(input string tag, input logic [63:0] m, input logic ng, dz, cov, o32, w32, sg);
    @(negedge clk);
    cur_tag = tag; in_valid = 1'b1; quo_mag = m; negate = ng; div_zero = dz;
    ovf_core = cov; ovf32 = o32; mode_32 = w32; mode_signed = sg;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; quo_mag = 64'hdead_beef_0bad_f00d; negate = 1'b1; div_zero = 1'b1;
    end
  endtask

  initial begin
    #1000000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || result !== '0 || overflow !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset got v=%0b res=%h ovf=%0b, expected 0 0 0", out_valid, result, overflow);
    end
    rst_n = 1'b1;
    op("R2", 64'd7, 1, 0, 0, 0, 0, 1);
    op("R2", 64'd7, 1, 0, 0, 0, 0, 0);
    idle(3);
    op("R3", 64'h8000_0000_0000_0000, 1, 0, 0, 0, 0, 1);
    op("R3", 64'h8000_0000_0000_0000, 0, 0, 0, 0, 0, 1);
    op("R3", 64'h7fff_ffff_ffff_ffff, 0, 0, 0, 0, 0, 1);
    op("R3", 64'hffff_ffff_ffff_ffff, 0, 0, 0, 0, 0, 0);
    op("R3", 64'd5, 0, 0, 1, 0, 0, 0);
    op("R3", 64'd5, 0, 0, 0, 1, 0, 1);
    op("R4", 64'h0000_0000_8000_0000, 1, 0, 0, 0, 1, 1);
    op("R4", 64'h0000_0000_8000_0000, 0, 0, 0, 0, 1, 1);
    op("R4", 64'h0000_0000_7fff_ffff, 0, 0, 0, 0, 1, 1);
    op("R4", 64'd9, 1, 0, 0, 1, 1, 1);
    op("R5", 64'hffff_ffff_ffff_ffff, 1, 0, 1, 0, 1, 0);
    op("R5", 64'd12, 0, 0, 0, 1, 1, 0);
    op("R6", 64'hfc00_0000_0000_0003, 1, 0, 0, 0, 1, 1);
    op("R6", 64'h0000_0001_0000_0003, 1, 0, 0, 0, 1, 1);
    op("R6", 64'habcd_0000_1234_5678, 0, 0, 0, 0, 1, 0);
    idle(2);
    op("R7", 64'd1, 0, 1, 0, 0, 0, 0);
    op("R7", 64'd1, 1, 1, 0, 0, 1, 1);
    op("R8", 64'hffff_ffff_ffff_fff0, 1, 0, 1, 0, 0, 1);
    op("R9", 64'h0000_0000_0000_0064, 1, 0, 0, 0, 1, 1);
    op("R9", 64'h0000_0000_9000_0001, 1, 0, 0, 0, 1, 0);
    idle(4);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule